// File: doc/BRIEF.md
# Ring-Chained Audio DMA Channel

This block is one DMA channel that carries 16-bit audio samples between system memory and a small halfword FIFO. It follows a closed ring of three-word descriptors in memory. Each descriptor names a buffer and gives it a byte count. The channel moves that many bytes, then jumps to the next descriptor and keeps going until software stops it. The ring has no terminating entry.

Software first loads the descriptor pointer and then writes the control word with the active bit set. The control word also chooses the transfer direction and holds a window (begin and end, in 64-bit units) that limits how much of the FIFO this channel may use, plus a watermark in halfwords. A byte-pointer register shows which buffer address is being moved, so software can track playback or capture position. A descriptor can ask for a completion interrupt; the channel latches this as a pending bit, and a read of the control register clears it.

Top module: `adma_channel`

## Requirements
- R1: After reset, all three registers read zero, and `irq`, `mem_req`, `tx_valid` and `rx_ready` are low.
- R2: A descriptor is three 32-bit words: buffer address at offset 0, info word at offset 4, next-descriptor address at offset 8. Info bits 15:0 hold the byte count and bit 31 enables a completion interrupt. After a start, the channel reads these three words in that order.
- R3: Register 0 is the control word: bit 0 active, bit 1 receive, bit 2 real-time, bit 3 load, bit 4 pending interrupt (read-only), bits 15:8 watermark in halfwords, bits 23:16 window begin, bits 31:24 window end. Register 1 is the descriptor pointer. Register 2 is the byte pointer. Reading bit 0 returns 1 while the channel runs.
- R4: In transmit (bit 1 clear), the channel issues a memory read only while the FIFO fill is below the watermark and two free halfword slots exist. The high half of each word reaches `tx_data` before the low half.
- R5: The FIFO capacity is (end − begin) × 4 halfwords, capped at FIFO_DEPTH, and is zero when end ≤ begin. The fill never exceeds this capacity.
- R6: In receive (bit 1 set), halfwords taken from `rx_data` are packed in pairs, the first one in bits 31:16. A memory write is issued only once the fill is at least the watermark and at least 2.
- R7: Once a descriptor's byte count has been moved, in 4-byte steps, the descriptor pointer takes the next address. The byte pointer shows the current buffer address.
- R8: A next address that points back to the first descriptor makes the channel continue round the ring without stopping.
- R9: A block whose info bit 31 is set makes the pending bit 1 when the block completes. `irq` follows the pending bit. A read of register 0 clears it, but a new completion in that same cycle wins.
- R10: A control write with bit 0 clear stops the channel and empties the FIFO. From the next cycle, there are no memory requests and no device handshakes.
- R11: A memory request that has not been granted stays asserted with the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears pending interrupt on register 0) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant; access completes in this cycle |
| mem_rdata | input | 32 | Memory read data, valid with grant |
| tx_data | output | 16 | Halfword to the device |
| tx_valid | output | 1 | Transmit halfword available |
| tx_ready | input | 1 | Device accepts transmit halfword |
| rx_data | input | 16 | Halfword from the device |
| rx_valid | input | 1 | Receive halfword offered |
| rx_ready | output | 1 | Channel accepts receive halfword |
| irq | output | 1 | Pending block-completion interrupt |

## Verification
A corrupted descriptor state shows up within one block as wrong memory addresses or a wrong byte-pointer readback. A counting error shows up as a missed or extra hop round the ring, which appears in the order of addresses in the next lap. A wrong FIFO fill or watermark compare shows up at once as a wrong number of memory reads while the device is stalled, or as a write issued early in receive. A lost or stuck pending bit shows up on the next read of the control word.

// File: rtl/adma_pkg.sv
package adma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DBUF,
    ST_DINFO,
    ST_DNEXT,
    ST_MOVE
  } eng_state_e;

  localparam int unsigned CTRL_ACT  = 0;
  localparam int unsigned CTRL_RCV  = 1;
  localparam int unsigned CTRL_RT   = 2;
  localparam int unsigned CTRL_LD   = 3;
  localparam int unsigned CTRL_PEND = 4;
  localparam int unsigned INFO_IE   = 31;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_DPTR = 2'd1;
  localparam logic [1:0] RA_BPTR = 2'd2;
endpackage

// File: rtl/adma_fifo.sv
module adma_fifo #(
  parameter int unsigned DEPTH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic [1:0]              wr_n,
  input  logic [15:0]             wr_hi,
  input  logic [15:0]             wr_lo,
  input  logic [1:0]              rd_n,
  output logic [15:0]             rd0,
  output logic [15:0]             rd1,
  output logic [$clog2(DEPTH):0]  fill
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [15:0]   slot_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] fill_q, fill_d;

  always_comb begin
    wp_d   = wp_q + AW'(wr_n);
    rp_d   = rp_q + AW'(rd_n);
    fill_d = fill_q + CW'(wr_n) - CW'(rd_n);
    if (flush) begin
      wp_d   = '0;
      rp_d   = '0;
      fill_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_n != 2'd0) slot_q[wp_q] <= wr_hi;
    if (wr_n == 2'd2) slot_q[wp_q + AW'(1)] <= wr_lo;
  end

  assign rd0  = slot_q[rp_q];
  assign rd1  = slot_q[rp_q + AW'(1)];
  assign fill = fill_q;
endmodule

// File: rtl/adma_engine.sv
module adma_engine
  import adma_pkg::*;
#(
  parameter int unsigned FILL_W = 4,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              halt,
  input  logic              dptr_we,
  input  logic [31:0]       dptr_wdata,
  input  logic              rcv,
  input  logic [FILL_W-1:0] fill,
  input  logic [FILL_W-1:0] cap,
  input  logic [7:0]        hwm,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  input  logic [15:0]       fifo_rd0,
  input  logic [15:0]       fifo_rd1,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              push_word,
  output logic              pop_word,
  output logic              blk_done,
  output logic              running,
  output logic [31:0]       dptr,
  output logic [31:0]       bptr
);
  eng_state_e       state_q, state_d;
  logic [31:0]      dptr_q, dptr_d, bptr_q, bptr_d, next_q, next_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             ie_q, ie_d;
  logic [15:0]      fill_w, cap_w, hw_w;
  logic             in_move, has_left, tx_want, rx_want, xfer_ok;

  assign fill_w   = 16'(fill);
  assign cap_w    = 16'(cap);
  assign hw_w     = 16'(hwm);
  assign in_move  = (state_q == ST_MOVE);
  assign has_left = (left_q != '0);
  assign tx_want  = in_move && !rcv && has_left && (fill_w < hw_w) && (fill_w + 16'd2 <= cap_w);
  assign rx_want  = in_move && rcv && has_left && (fill_w >= hw_w) && (fill_w >= 16'd2);

  always_comb begin
    unique case (state_q)
      ST_DBUF:  mem_addr = dptr_q;
      ST_DINFO: mem_addr = dptr_q + 32'd4;
      ST_DNEXT: mem_addr = dptr_q + 32'd8;
      default:  mem_addr = bptr_q;
    endcase
  end

  assign mem_req   = (state_q == ST_DBUF) || (state_q == ST_DINFO) ||
                     (state_q == ST_DNEXT) || tx_want || rx_want;
  assign mem_we    = rx_want;
  assign mem_wdata = {fifo_rd0, fifo_rd1};
  assign xfer_ok   = (tx_want || rx_want) && mem_gnt && !halt && !go;
  assign push_word = xfer_ok && !rcv;
  assign pop_word  = xfer_ok && rcv;
  assign blk_done  = in_move && !has_left && ie_q && !halt && !go;
  assign running   = (state_q != ST_IDLE);
  assign dptr      = dptr_q;
  assign bptr      = bptr_q;

  always_comb begin
    state_d = state_q;
    dptr_d  = dptr_q;
    bptr_d  = bptr_q;
    next_d  = next_q;
    left_d  = left_q;
    ie_d    = ie_q;
    if (halt) begin
      state_d = ST_IDLE;
    end else if (go) begin
      state_d = ST_DBUF;
    end else begin
      unique case (state_q)
        ST_DBUF: if (mem_gnt) begin
          bptr_d  = mem_rdata;
          state_d = ST_DINFO;
        end
        ST_DINFO: if (mem_gnt) begin
          left_d  = mem_rdata[CNT_W-1:0];
          ie_d    = mem_rdata[INFO_IE];
          state_d = ST_DNEXT;
        end
        ST_DNEXT: if (mem_gnt) begin
          next_d  = mem_rdata;
          state_d = ST_MOVE;
        end
        ST_MOVE: begin
          if (!has_left) begin
            dptr_d  = next_q;
            state_d = ST_DBUF;
          end else if (xfer_ok) begin
            bptr_d = bptr_q + 32'd4;
            left_d = (left_q > CNT_W'(4)) ? left_q - CNT_W'(4) : '0;
          end
        end
        default: ;
      endcase
    end
    if (dptr_we) dptr_d = dptr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dptr_q  <= '0;
      bptr_q  <= '0;
      next_q  <= '0;
      left_q  <= '0;
      ie_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      dptr_q  <= dptr_d;
      bptr_q  <= bptr_d;
      next_q  <= next_d;
      left_q  <= left_d;
      ie_q    <= ie_d;
    end
  end
endmodule

// File: rtl/adma_channel.sv
module adma_channel
  import adma_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned CNT_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic [31:0] mem_rdata,
  output logic [15:0] tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic [15:0] rx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  output logic        irq
);
  localparam int unsigned FILL_W = $clog2(FIFO_DEPTH) + 1;

  logic        rcv_q, rcv_d, rt_q, rt_d, ld_q, ld_d, pend_q, pend_d;
  logic [7:0]  hwm_q, hwm_d, fbeg_q, fbeg_d, fend_q, fend_d;
  logic        ctrl_wr, ctrl_rd, go, halt, dptr_we;
  logic        push_word, pop_word, blk_done, running;
  logic [31:0] dptr, bptr;
  logic [15:0] rd0, rd1;
  logic [FILL_W-1:0] fill, cap;
  logic [9:0]  span_hw;
  logic [1:0]  wr_n, rd_n;

  assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
  assign ctrl_rd = reg_rd && (reg_addr == RA_CTRL);
  assign go      = ctrl_wr && reg_wdata[CTRL_ACT];
  assign halt    = ctrl_wr && !reg_wdata[CTRL_ACT];
  assign dptr_we = reg_wr && (reg_addr == RA_DPTR);

  assign span_hw = (fend_q > fbeg_q) ? {fend_q - fbeg_q, 2'b00} : 10'd0;
  assign cap     = (span_hw > 10'(FIFO_DEPTH)) ? FILL_W'(FIFO_DEPTH) : FILL_W'(span_hw);

  always_comb begin
    rcv_d  = rcv_q;
    rt_d   = rt_q;
    ld_d   = ld_q;
    hwm_d  = hwm_q;
    fbeg_d = fbeg_q;
    fend_d = fend_q;
    pend_d = pend_q;
    if (ctrl_wr) begin
      rcv_d  = reg_wdata[CTRL_RCV];
      rt_d   = reg_wdata[CTRL_RT];
      ld_d   = reg_wdata[CTRL_LD];
      hwm_d  = reg_wdata[15:8];
      fbeg_d = reg_wdata[23:16];
      fend_d = reg_wdata[31:24];
    end
    if (ctrl_rd)  pend_d = 1'b0;
    if (blk_done) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcv_q  <= 1'b0;
      rt_q   <= 1'b0;
      ld_q   <= 1'b0;
      hwm_q  <= '0;
      fbeg_q <= '0;
      fend_q <= '0;
      pend_q <= 1'b0;
    end else begin
      rcv_q  <= rcv_d;
      rt_q   <= rt_d;
      ld_q   <= ld_d;
      hwm_q  <= hwm_d;
      fbeg_q <= fbeg_d;
      fend_q <= fend_d;
      pend_q <= pend_d;
    end
  end

  assign tx_valid = running && !rcv_q && (fill != '0);
  assign tx_data  = rd0;
  assign rx_ready = running && rcv_q && (fill < cap);
  assign irq      = pend_q;

  assign wr_n = rcv_q ? ((rx_valid && rx_ready) ? 2'd1 : 2'd0) : (push_word ? 2'd2 : 2'd0);
  assign rd_n = rcv_q ? (pop_word ? 2'd2 : 2'd0) : ((tx_valid && tx_ready) ? 2'd1 : 2'd0);

  always_comb begin
    unique case (reg_addr)
      RA_CTRL: reg_rdata = {fend_q, fbeg_q, hwm_q, 3'b000, pend_q, ld_q, rt_q, rcv_q, running};
      RA_DPTR: reg_rdata = dptr;
      RA_BPTR: reg_rdata = bptr;
      default: reg_rdata = '0;
    endcase
  end

  adma_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (ctrl_wr),
    .wr_n  (wr_n),
    .wr_hi (rcv_q ? rx_data : mem_rdata[31:16]),
    .wr_lo (mem_rdata[15:0]),
    .rd_n  (rd_n),
    .rd0   (rd0),
    .rd1   (rd1),
    .fill  (fill)
  );

  adma_engine #(.FILL_W(FILL_W), .CNT_W(CNT_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .halt       (halt),
    .dptr_we    (dptr_we),
    .dptr_wdata (reg_wdata),
    .rcv        (rcv_q),
    .fill       (fill),
    .cap        (cap),
    .hwm        (hwm_q),
    .mem_gnt    (mem_gnt),
    .mem_rdata  (mem_rdata),
    .fifo_rd0   (rd0),
    .fifo_rd1   (rd1),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .push_word  (push_word),
    .pop_word   (pop_word),
    .blk_done   (blk_done),
    .running    (running),
    .dptr       (dptr),
    .bptr       (bptr)
  );
endmodule

// File: rtl/adma_channel_chk.sv
module adma_channel_chk #(
  parameter int unsigned FILL_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [1:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_gnt,
  input logic [31:0]       mem_addr,
  input logic              irq,
  input logic              tx_valid,
  input logic              rx_ready,
  input logic              rcv,
  input logic [FILL_W-1:0] fill,
  input logic [FILL_W-1:0] cap
);
  a_r5_fill_within_window: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= cap);

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !reg_wr) |=> (mem_req && $stable(mem_addr)));

  a_r4_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

  a_r6_write_only_receive: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> rcv);

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_rd && reg_addr == 2'd0)) |=> irq);

  a_r10_quiet_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && !reg_wdata[0]) |=> (!mem_req && !tx_valid && !rx_ready));
endmodule

bind adma_channel adma_channel_chk #(.FILL_W(FILL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_gnt   (mem_gnt),
  .mem_addr  (mem_addr),
  .irq       (irq),
  .tx_valid  (tx_valid),
  .rx_ready  (rx_ready),
  .rcv       (rcv_q),
  .fill      (fill),
  .cap       (cap)
);

// File: tb/adma_channel_tb.sv
`timescale 1ns/1ps
module adma_channel_tb;
  logic        clk, rst_n;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [15:0] tx_data, rx_data;
  logic        tx_valid, tx_ready, rx_valid, rx_ready, irq;

  adma_channel u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] cyc = 0;
  logic [31:0] mem_arr [64];
  logic        stall = 1'b0;
  int          tx_left = 0, rx_left = 0, rx_idx = 0;
  int          rd_n = 0, n_data_rd = 0, n_wr = 0;
  logic [31:0] rd_log [16];
  logic [31:0] last_data_addr = 0;
  logic [15:0] tx_exp [$];
  logic [63:0] wr_exp [$];

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mem_gnt   = mem_req && !stall;
  assign mem_rdata = mem_arr[mem_addr[7:2]];

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // driver side of the scoreboard: expected transmit halfwords for N laps
  task automatic push_tx_laps(input int laps);
    for (int l = 0; l < laps; l++) begin
      tx_exp.push_back(mem_arr[16][31:16]); tx_exp.push_back(mem_arr[16][15:0]);
      tx_exp.push_back(mem_arr[17][31:16]); tx_exp.push_back(mem_arr[17][15:0]);
      tx_exp.push_back(mem_arr[32][31:16]); tx_exp.push_back(mem_arr[32][15:0]);
    end
  endtask

  // monitor: device handshakes and memory accesses, sampled between edges
  always @(negedge clk) begin
    stall    = (cyc % 4 == 1);
    tx_ready = (tx_left > 0) && (cyc % 3 != 0);
    if (rx_left > 0) begin
      rx_valid = cyc[0];
      rx_data  = 16'hA000 + 16'(rx_idx);
    end else begin
      rx_valid = 1'b0;
    end
    #1;
    if (tx_valid && tx_ready) begin
      tx_left--;
      if (tx_exp.size() == 0) chk(1'b0, "R4 unexpected tx halfword", 64'(tx_data), 64'h0);
      else begin
        logic [15:0] e;
        e = tx_exp.pop_front();
        chk(tx_data == e, "R4 tx halfword order", 64'(tx_data), 64'(e));
      end
    end
    if (rx_valid && rx_ready) begin
      rx_idx++;
      rx_left--;
    end
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        n_wr++;
        if (wr_exp.size() == 0) chk(1'b0, "R6 unexpected write", {mem_addr, mem_wdata}, 64'h0);
        else begin
          logic [63:0] e;
          e = wr_exp.pop_front();
          chk({mem_addr, mem_wdata} == e, "R6 rx write addr/data", {mem_addr, mem_wdata}, e);
        end
      end else begin
        if (rd_n < 16) rd_log[rd_n] = mem_addr;
        rd_n++;
        if (mem_addr >= 32'h40) begin
          n_data_rd++;
          last_data_addr = mem_addr;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int quiet;
    for (int i = 0; i < 64; i++) mem_arr[i] = 32'h0;
    mem_arr[0] = 32'h40; mem_arr[1] = 32'h8000_0008; mem_arr[2] = 32'h0C;
    mem_arr[3] = 32'h80; mem_arr[4] = 32'h0000_0004; mem_arr[5] = 32'h00;
    mem_arr[16] = 32'h1111_2222; mem_arr[17] = 32'h3333_4444; mem_arr[32] = 32'h5555_6666;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd0; reg_wdata = 32'h0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_data = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #1 chk(!irq && !mem_req && !tx_valid && !rx_ready, "R1 outputs after reset",
           {60'h0, irq, mem_req, tx_valid, rx_ready}, 64'h0);
    reg_read(2'd0, rd); chk(rd == 32'h0, "R1 ctrl reset", 64'(rd), 64'h0);
    reg_read(2'd1, rd); chk(rd == 32'h0, "R1 dptr reset", 64'(rd), 64'h0);
    reg_read(2'd2, rd); chk(rd == 32'h0, "R1 bptr reset", 64'(rd), 64'h0);

    // transmit with stalled device: watermark 4, window 0..2
    reg_write(2'd1, 32'h0);
    rd_n = 0; n_data_rd = 0;
    reg_write(2'd0, 32'h0200_0401);
    repeat (40) @(negedge clk);
    chk(rd_log[0] == 32'h00 && rd_log[1] == 32'h04 && rd_log[2] == 32'h08 && rd_log[3] == 32'h40 &&
        rd_log[4] == 32'h44 && rd_log[5] == 32'h0C && rd_log[6] == 32'h10 && rd_log[7] == 32'h14,
        "R2 fetch order", {rd_log[5], rd_log[6]}, {32'h0C, 32'h10});
    chk(n_data_rd == 2, "R4 reads stop at watermark", 64'(n_data_rd), 64'd2);
    chk(irq == 1'b1, "R9 irq after block A", 64'(irq), 64'd1);
    reg_read(2'd2, rd); chk(rd == 32'h80, "R7 bptr on block B", 64'(rd), 64'h80);
    reg_read(2'd1, rd); chk(rd == 32'h0C, "R7 dptr advanced", 64'(rd), 64'h0C);
    reg_read(2'd0, rd); chk(rd == 32'h0200_0411, "R3 R9 ctrl readback pending", 64'(rd), 64'h0200_0411);
    reg_read(2'd0, rd); chk(rd == 32'h0200_0401, "R9 pending cleared by read", 64'(rd), 64'h0200_0401);
    chk(irq == 1'b0, "R9 irq low after read", 64'(irq), 64'd0);

    // stream three laps round the ring (R8)
    push_tx_laps(5);
    tx_left = 18;
    wait (tx_left == 0);
    chk(tx_exp.size() == 12, "R8 three laps consumed", 64'(tx_exp.size()), 64'd12);
    reg_write(2'd0, 32'h0000_0008);
    quiet = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      if (mem_req || tx_valid) quiet++;
    end
    chk(quiet == 0, "R10 quiet after stop", 64'(quiet), 64'd0);
    reg_read(2'd0, rd); chk((rd & ~32'h10) == 32'h08, "R3 stopped ctrl", 64'(rd), 64'h08);
    tx_exp.delete();

    // window clamp: window 0..8 exceeds depth, watermark 255 (R5, R8 wrap)
    reg_write(2'd1, 32'h0);
    rd_n = 0; n_data_rd = 0;
    reg_write(2'd0, 32'h0800_FF01);
    repeat (60) @(negedge clk);
    chk(n_data_rd == 4, "R5 fill capped at depth", 64'(n_data_rd), 64'd4);
    chk(last_data_addr == 32'h40, "R8 wrap to first buffer", 64'(last_data_addr), 64'h40);
    reg_write(2'd0, 32'h0000_0008);

    // empty window in receive (R5)
    n_wr = 0;
    reg_write(2'd0, 32'h0404_0003);
    rx_left = 4;
    repeat (20) @(negedge clk);
    chk(rx_ready == 1'b0 && rx_left == 4, "R5 zero window accepts nothing", 64'(rx_left), 64'd4);
    chk(n_wr == 0, "R5 no writes with zero window", 64'(n_wr), 64'd0);
    reg_write(2'd0, 32'h0000_0008);
    rx_left = 0;

    // receive: watermark 4, window 2..4
    reg_write(2'd1, 32'h0);
    n_wr = 0; rx_idx = 0;
    wr_exp.push_back({32'h40, 32'hA000_A001});
    wr_exp.push_back({32'h44, 32'hA002_A003});
    wr_exp.push_back({32'h80, 32'hA004_A005});
    wr_exp.push_back({32'h40, 32'hA006_A007});
    wr_exp.push_back({32'h44, 32'hA008_A009});
    wr_exp.push_back({32'h80, 32'hA00A_A00B});
    reg_write(2'd0, 32'h0402_0403);
    rx_left = 12;
    wait (rx_left == 0);
    repeat (60) @(negedge clk);
    chk(n_wr == 5, "R6 last pair held below watermark", 64'(n_wr), 64'd5);
    chk(wr_exp.size() == 1, "R6 one write outstanding", 64'(wr_exp.size()), 64'd1);
    reg_write(2'd0, 32'h0000_0008);
    wr_exp.delete();
    repeat (5) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule